// File: doc/BRIEF.md
# Dual Tapped Serial Shift Register with Segment Loading

The block holds two independent 64-stage serial shift registers. Each lane has its own clock, write-enable, serial data input and four taps. The 64 stages of a lane form four equal 16-stage segments. A tap sits on the last stage of each segment, so the taps show stages 16, 32, 48 and 64. Each tap is split into three signals: a value driven out, an enable for that driver, and a value sampled in. The enclosing logic combines them into a shared bus line.

With write-enable low, the four segments chain into one 64-stage delay line and every tap drives. With write-enable high, every tap driver is released. The first stage of segments 2, 3 and 4 then takes the value on the tap that ends the segment before it. The serial input keeps feeding segment 1. Clocking in this mode fills all four segments side by side, so a full 64-bit image loads in 16 clocks.

There is no reset. The contents are undefined until 64 normal-mode clocks or 16 write-mode clocks have occurred.

All data pins are plain levels sampled on each lane's rising clock edge. Every rising edge is one shift, so a valid/ready handshake would have nothing to pace, and none is provided.

Top module: `tapped_shift_dual`

## Requirements
- R1: Each lane holds 64 stages in four 16-stage segments. Tap k (k = 0..3) presents stage 16(k+1) on `tap_out[lane][k]` at all times, whether or not its driver is enabled.
- R2: On every rising edge of a lane's clock, the lane's serial input enters stage 1, whatever the state of write-enable.
- R3: While write-enable is low, the first stage of segment k+1 takes the last stage of segment k. A bit on the serial input therefore reaches `tap_out[lane][3]` after 64 clocks.
- R4: `tap_oe[lane][k]` is 1 exactly while the lane's write-enable is 0, for all four taps including the stage-64 tap.
- R5: While write-enable is high, the first stage of segment k+1 (k = 0..2) takes `tap_in[lane][k]` on the clock edge. While write-enable is low, `tap_in` has no effect.
- R6: 16 write-mode clocks fully load a lane. Afterwards segment 0 holds the last 16 serial-input values and segment k+1 holds the last 16 values of `tap_in[lane][k]`, with the newest value in the first stage. Each tap then shows the oldest of the 16 values.
- R7: Tap outputs change only on the rising edge of their lane's clock. Changing the data inputs between edges leaves them unchanged.
- R8: The lanes are independent. Clocking one lane, or changing its inputs, leaves the other lane's taps unchanged.
- R9: `tap_in[lane][3]` (the stage-64 tap) feeds no segment and has no effect in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 2 | Per-lane shift clock, rising edge active |
| we | input | 2 | Per-lane write-enable: 1 = releases the taps and loads the segments from them |
| din | input | 2 | Per-lane serial data input into stage 1 |
| tap_in | input | 2x4 | Per-lane, per-tap value sampled from the bus in write mode |
| tap_out | output | 2x4 | Per-lane, per-tap value of stages 16/32/48/64 |
| tap_oe | output | 2x4 | Per-lane, per-tap driver enable, high in normal mode |

## Verification
Two things happen on the same edge in write mode. The serial input enters segment 0, and the tap values enter segments 1 to 3. A tap also shows the last stage of its own segment while its input value feeds the next segment. The bench drives unrelated patterns on the serial input and the tap inputs, so a swapped or dropped source shows up on a tap within 16 clocks. The second case is both lanes clocked on the same edge with different write-enable values. This is provoked by random per-lane clock masks and random mode toggles, and judged against a per-lane behavioural model on every step.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int unsigned TSR_LANES   = 2;
  localparam int unsigned TSR_SEGS    = 4;
  localparam int unsigned TSR_SEG_LEN = 16;
  localparam int unsigned TSR_DEPTH   = TSR_SEGS * TSR_SEG_LEN;
endpackage

// File: rtl/tsr_segment.sv
module tsr_segment #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic feed,
  output logic head,
  output logic tail
);
  logic [LEN-1:0] stg;
  logic           primed = 1'b0;

  always_ff @(posedge clk) begin
    stg    <= {stg[LEN-2:0], feed};
    primed <= 1'b1;
  end

  assign head = stg[0];
  assign tail = stg[LEN-1];

  AST_SEG_ADVANCE: assert property (@(posedge clk) disable iff (!primed)
    stg[LEN-1] === $past(stg[LEN-2])); // R1
endmodule

// File: rtl/tsr_lane.sv
module tsr_lane #(
  parameter int unsigned SEGS = 4,
  parameter int unsigned LEN  = 16
) (
  input  logic            clk,
  input  logic            we,
  input  logic            din,
  input  logic [SEGS-1:0] tap_in,
  output logic [SEGS-1:0] tap_out,
  output logic [SEGS-1:0] tap_oe
);
  logic [SEGS-1:0] feed;
  logic [SEGS-1:0] head;
  logic [SEGS-1:0] tail;
  logic            primed = 1'b0;

  always_ff @(posedge clk) primed <= 1'b1;

  assign feed[0] = din;

  for (genvar k = 0; k < SEGS; k++) begin : g_seg
    if (k > 0) begin : g_link
      assign feed[k] = we ? tap_in[k-1] : tail[k-1];

      AST_CHAIN_LINK: assert property (@(posedge clk) disable iff (!primed)
        !$past(we) |-> head[k] === $past(tail[k-1])); // R3
      AST_TAP_LOAD: assert property (@(posedge clk) disable iff (!primed)
        $past(we) |-> head[k] === $past(tap_in[k-1])); // R5
    end
    tsr_segment #(.LEN(LEN)) u_seg (
      .clk  (clk),
      .feed (feed[k]),
      .head (head[k]),
      .tail (tail[k])
    );
  end

  assign tap_out = tail;
  assign tap_oe  = {SEGS{~we}};

  AST_SERIAL_ENTRY: assert property (@(posedge clk) disable iff (!primed)
    head[0] === $past(din)); // R2
endmodule

// File: rtl/tapped_shift_dual.sv
module tapped_shift_dual
  import tsr_pkg::*;
#(
  parameter int unsigned LANES   = TSR_LANES,
  parameter int unsigned SEGS    = TSR_SEGS,
  parameter int unsigned SEG_LEN = TSR_SEG_LEN
) (
  input  logic [LANES-1:0]           clk,
  input  logic [LANES-1:0]           we,
  input  logic [LANES-1:0]           din,
  input  logic [LANES-1:0][SEGS-1:0] tap_in,
  output logic [LANES-1:0][SEGS-1:0] tap_out,
  output logic [LANES-1:0][SEGS-1:0] tap_oe
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tsr_lane #(.SEGS(SEGS), .LEN(SEG_LEN)) u_lane (
      .clk     (clk[l]),
      .we      (we[l]),
      .din     (din[l]),
      .tap_in  (tap_in[l]),
      .tap_out (tap_out[l]),
      .tap_oe  (tap_oe[l])
    );
  end
endmodule

// File: tb/tapped_shift_dual_tb.sv
module tapped_shift_dual_tb;
  localparam int L = 2;
  localparam int S = 4;
  localparam int N = 64;

  logic [L-1:0]        clk = '0;
  logic [L-1:0]        we = '0;
  logic [L-1:0]        din = '0;
  logic [L-1:0][S-1:0] tap_in = '0;
  logic [L-1:0][S-1:0] tap_out;
  logic [L-1:0][S-1:0] tap_oe;

  int checks = 0;
  int errors = 0;
  bit mdl [L][N];
  bit done = 0;

  tapped_shift_dual u_dut (
    .clk(clk), .we(we), .din(din), .tap_in(tap_in),
    .tap_out(tap_out), .tap_oe(tap_oe)
  );

  function automatic logic [S-1:0] exp_taps(int l);
    logic [S-1:0] v;
    for (int k = 0; k < S; k++) v[k] = mdl[l][16*k+15];
    return v;
  endfunction

  task automatic chk(string req, logic [S-1:0] act, logic [S-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clock(int l);
    bit nxt [N];
    for (int j = N-1; j > 0; j--) begin
      if (j % 16 == 0 && we[l]) nxt[j] = tap_in[l][j/16-1];
      else                      nxt[j] = mdl[l][j-1];
    end
    nxt[0] = din[l];
    for (int j = 0; j < N; j++) mdl[l][j] = nxt[j];
  endtask

  // one 4 ns period (250 MHz): edge at +1, compare at +2
  task automatic step(logic [L-1:0] mask, string req);
    #1;
    for (int l = 0; l < L; l++) if (mask[l]) model_clock(l);
    clk = mask;
    #1;
    for (int l = 0; l < L; l++) begin
      chk(req, tap_out[l], exp_taps(l));
      chk("R4", tap_oe[l], {S{~we[l]}});
    end
    #1 clk = '0;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pat [S];
    logic [S-1:0] held;
    // R6: 16-clock parallel load of lane 0, lane 1 loaded the same way
    pat[0] = 16'hA5C3; pat[1] = 16'h0FF0; pat[2] = 16'h3C96; pat[3] = 16'hFFFF;
    we = 2'b11;
    #1;
    chk("R4", tap_oe[0], 4'b0000);
    chk("R4", tap_oe[1], 4'b0000);
    for (int t = 0; t < 16; t++) begin
      for (int l = 0; l < L; l++) begin
        din[l] = pat[0][t] ^ l[0];
        for (int k = 0; k < 3; k++) tap_in[l][k] = pat[k+1][t];
        tap_in[l][3] = pat[3][t];  // R9: no segment takes it
      end
      #1;
      for (int l = 0; l < L; l++) model_clock(l);
      clk = 2'b11;
      #1 clk = '0;
      #2;
    end
    for (int l = 0; l < L; l++) begin
      held[0] = pat[0][0] ^ l[0];
      held[1] = pat[1][0]; held[2] = pat[2][0]; held[3] = pat[3][0];
      chk("R6", tap_out[l], held);
    end
    // R7: changing inputs between edges leaves taps unchanged
    held = tap_out[0];
    din = ~din; tap_in = ~tap_in; #1;
    chk("R7", tap_out[0], held);
    // R4/R3: normal mode, stage-64 output delay line; R5/R9 tap_in ignored
    we = 2'b00;
    for (int t = 0; t < 80; t++) begin
      din = 2'($urandom);
      tap_in = 8'($urandom);
      step(2'b01, "R3");
    end
    // R8: clock lane 1 only, lane 0 must stay put
    held = tap_out[0];
    for (int t = 0; t < 20; t++) begin
      din = 2'($urandom);
      we[1] = 1'($urandom);
      tap_in = 8'($urandom);
      step(2'b10, "R8");
      chk("R8", tap_out[0], held);
    end
    // R2/R5/R9: write mode on lane 0, stage-64 tap input toggling
    we = 2'b01;
    for (int t = 0; t < 40; t++) begin
      din = 2'($urandom);
      tap_in = 8'($urandom);
      step(2'b01, "R5");
    end
    // concurrent lanes, random modes and masks
    for (int t = 0; t < 400; t++) begin
      din = 2'($urandom);
      we = 2'($urandom);
      tap_in = 8'($urandom);
      step(2'($urandom) | 2'b01, "R1");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule